// File: doc/BRIEF.md
# Serial Link Training Controller

This block is the receiver-side controller that brings up a multi-lane high-speed serial link after a cable is plugged in. It reads three status inputs for each lane: frequency lock, symbol lock and error events. It steps through two training phases in a fixed order. Phase one waits for every active lane to lock its frequency on an alternating one-zero pattern. Phase two checks symbol alignment and the error rate over a fixed window while more complex patterns are sent.

While it trains, the controller sets the level of drive it asks the source for. It also sets the pre-emphasis it asks for and the settings of its own equalizer. When one rate cannot be trained, it asks the source to drop to the low rate and starts over. When the low rate also fails, it stops in a failed state. It uses a one-cycle attention pulse on the hot-plug line to call the source whenever the link is lost or training fails. A training state code is exported for the source to poll.

Top module: `link_train_ctrl`

## Requirements
- R1: After reset the state code `train_st` is 0 (idle). `link_ready`, `attn`, `rate_low`, `lanes_act` and all level outputs are 0.
- R2: `plug_evt` is acted on only in idle (code 0) or failed (code 4). It moves the controller to phase one (code 1) and clears the rate (`rate_low`=0) and all levels. It sets `lanes_act` to `lane_req` clamped to 1..NLANE, so a request of 0 gives 1. In any other state `plug_evt` is ignored and `lanes_act` does not change.
- R3: In phase one, the controller enters phase two (code 2) on the edge after every active lane (lanes 0 to `lanes_act`-1) shows `freq_lock`. The lock bits of inactive lanes are ignored.
- R4: In phase one, each P1_WIN cycles without full lock are one failed try. Each failed try raises `drive_lvl` by one, and the level saturates at 3. Failed try number P1_TRIES does not raise the drive level; it exhausts the current rate instead.
- R5: Phase two judges a window of P2_WIN cycles. The window passes if all active lanes show `sym_lock` in its last cycle and the total number of error events on active lanes is at most `thresh`. The total counts every set bit of `err_evt`, each cycle. A pass moves the controller to ready (code 3) with `link_ready`=1.
- R6: A phase-two window that does not pass is one failed try. It raises `pre_lvl` and `eq_lvl` by one each (saturating at 3), sets `eq_en`, and starts a new window. Error events on inactive lanes never count.
- R7: Failed phase-two try number P2_TRIES exhausts the current rate.
- R8: When the high rate (`rate_low`=0) is exhausted, the controller sets `rate_low`=1, clears all levels and restarts phase one with fresh try counts. `rate_low` stays at 1 until the next accepted `plug_evt`.
- R9: When the low rate is exhausted, the controller enters failed (code 4) with `link_ready`=0. `attn` is high for exactly the first cycle in that state.
- R10: In ready, losing `freq_lock` or `sym_lock` on any active lane returns the controller to phase one (code 1) on the next edge. `attn` is high for that one cycle, and `rate_low` is kept. Lock changes on inactive lanes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| plug_evt | input | 1 | Hot-plug event, starts training |
| lane_req | input | LCW | Requested lane count |
| thresh | input | CW | Error threshold for one phase-two window |
| freq_lock | input | NLANE | Per-lane frequency lock |
| sym_lock | input | NLANE | Per-lane symbol lock |
| err_evt | input | NLANE | Per-lane error event this cycle |
| train_st | output | 3 | State code: 0 idle, 1 phase one, 2 phase two, 3 ready, 4 failed |
| drive_lvl | output | 2 | Requested drive level |
| pre_lvl | output | 2 | Requested pre-emphasis level |
| eq_en | output | 1 | Receiver equalizer enable |
| eq_lvl | output | 2 | Receiver equalizer level |
| rate_low | output | 1 | 1 requests the low link rate |
| lanes_act | output | LCW | Active lane count |
| link_ready | output | 1 | Link trained and usable |
| attn | output | 1 | One-cycle attention pulse to the source |

## Verification
Lane count requests are swept from 0 to 7 to cover the clamp at both ends. Phase one is held with no lock for the full try budget at both rates. This separates the drive ramp and its saturation from the rate fallback and the final failure, and each state change is checked on its exact cycle. Phase two is tried with error counts swept across the threshold, with two errors in a single cycle, with a missing symbol lock, and with constant noise on inactive lanes. These patterns separate the limit comparison itself from the per-cycle counting and from the lane masking. In ready, lock is removed first on an inactive lane and then on an active one. This shows that only active lanes can drop the link.

// File: rtl/lt_pkg.sv
package lt_pkg;

    localparam int LVL_W = 2;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PH1   = 3'd1,
        ST_PH2   = 3'd2,
        ST_READY = 3'd3,
        ST_FAIL  = 3'd4
    } tst_e;

    typedef struct packed {
        lvl_t drive;
        lvl_t pre;
        logic eq_en;
        lvl_t eq;
    } lvl_s;

    function automatic lvl_t lvl_inc(input lvl_t v);
        return (v == '1) ? v : lvl_t'(v + lvl_t'(1));
    endfunction

endpackage

// File: rtl/lt_lane_mon.sv
module lt_lane_mon #(
    parameter int NL  = 4,
    parameter int LCW = 3,
    parameter int EW  = 3
) (
    input  logic [LCW-1:0] lanes_act,
    input  logic [NL-1:0]  freq_lock,
    input  logic [NL-1:0]  sym_lock,
    input  logic [NL-1:0]  err_evt,
    output logic           all_freq,
    output logic           all_sym,
    output logic [EW-1:0]  err_cnt
);
    logic [NL-1:0] mask;
    logic [NL-1:0] hits;

    for (genvar i = 0; i < NL; i++) begin : g_mask
        assign mask[i] = (lanes_act > LCW'(i));
    end

    assign all_freq = &(freq_lock | ~mask);
    assign all_sym  = &(sym_lock | ~mask);
    assign hits     = err_evt & mask;

    always_comb begin
        err_cnt = '0;
        for (int i = 0; i < NL; i++) begin
            err_cnt = err_cnt + EW'(hits[i]);
        end
    end

endmodule

// File: rtl/lt_window.sv
module lt_window #(
    parameter int TW = 5,
    parameter int CW = 8,
    parameter int EW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [EW-1:0] add,
    input  logic [TW-1:0] lim,
    output logic          last,
    output logic [CW-1:0] acc_nxt
);
    logic [TW-1:0] tmr;
    logic [CW-1:0] acc;
    logic [CW:0]   sum;

    assign sum     = {1'b0, acc} + (CW+1)'(add);
    assign acc_nxt = sum[CW] ? '1 : sum[CW-1:0];
    assign last    = (tmr == lim - TW'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tmr <= '0;
            acc <= '0;
        end else begin
            tmr <= tmr + TW'(1);
            acc <= acc_nxt;
        end
    end

    AST_ERR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !clr |=> acc >= $past(acc)); // R6

endmodule

// File: rtl/lt_levels.sv
module lt_levels
    import lt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic drv_up,
    input  logic eq_up,
    output lvl_s lv
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lv <= '0;
        end else begin
            if (drv_up) lv.drive <= lvl_inc(lv.drive);
            if (eq_up) begin
                lv.pre   <= lvl_inc(lv.pre);
                lv.eq    <= lvl_inc(lv.eq);
                lv.eq_en <= 1'b1;
            end
        end
    end

    AST_DRIVE_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        !clr |=> lv.drive >= $past(lv.drive)); // R4
    AST_EQ_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        !clr |=> lv.eq >= $past(lv.eq)); // R6

endmodule

// File: rtl/link_train_ctrl.sv
module link_train_ctrl
    import lt_pkg::*;
#(
    parameter int NLANE    = 4,
    parameter int LCW      = $clog2(NLANE + 1),
    parameter int CW       = 8,
    parameter int P1_WIN   = 8,
    parameter int P2_WIN   = 16,
    parameter int P1_TRIES = 5,
    parameter int P2_TRIES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             plug_evt,
    input  logic [LCW-1:0]   lane_req,
    input  logic [CW-1:0]    thresh,
    input  logic [NLANE-1:0] freq_lock,
    input  logic [NLANE-1:0] sym_lock,
    input  logic [NLANE-1:0] err_evt,
    output logic [2:0]       train_st,
    output logic [1:0]       drive_lvl,
    output logic [1:0]       pre_lvl,
    output logic             eq_en,
    output logic [1:0]       eq_lvl,
    output logic             rate_low,
    output logic [LCW-1:0]   lanes_act,
    output logic             link_ready,
    output logic             attn
);
    localparam int EW  = $clog2(NLANE + 1);
    localparam int TW  = $clog2((P1_WIN > P2_WIN ? P1_WIN : P2_WIN) + 1);
    localparam int P1W = $clog2(P1_TRIES + 1);
    localparam int P2W = $clog2(P2_TRIES + 1);

    tst_e           st, st_n;
    logic           rate_n, attn_n;
    logic [LCW-1:0] lanes_n;
    logic [P1W-1:0] p1_try, p1_n;
    logic [P2W-1:0] p2_try, p2_n;
    logic           win_clr, lv_clr, drv_up, eq_up, exhaust;
    logic [TW-1:0]  win_lim;
    logic           win_last, all_freq, all_sym;
    logic [EW-1:0]  err_cnt;
    logic [CW-1:0]  err_tot;
    lvl_s           lv;

    function automatic logic [LCW-1:0] clamp_lanes(input logic [LCW-1:0] r);
        if (r == '0)                  return LCW'(1);
        else if (r > LCW'(NLANE))     return LCW'(NLANE);
        else                          return r;
    endfunction

    lt_lane_mon #(.NL(NLANE), .LCW(LCW), .EW(EW)) u_mon (
        .lanes_act (lanes_act),
        .freq_lock (freq_lock),
        .sym_lock  (sym_lock),
        .err_evt   (err_evt),
        .all_freq  (all_freq),
        .all_sym   (all_sym),
        .err_cnt   (err_cnt)
    );

    lt_window #(.TW(TW), .CW(CW), .EW(EW)) u_win (
        .clk     (clk),
        .rst     (rst),
        .clr     (win_clr),
        .add     (err_cnt),
        .lim     (win_lim),
        .last    (win_last),
        .acc_nxt (err_tot)
    );

    lt_levels u_lvl (
        .clk    (clk),
        .rst    (rst),
        .clr    (lv_clr),
        .drv_up (drv_up),
        .eq_up  (eq_up),
        .lv     (lv)
    );

    always_comb begin
        st_n    = st;
        rate_n  = rate_low;
        lanes_n = lanes_act;
        p1_n    = p1_try;
        p2_n    = p2_try;
        attn_n  = 1'b0;
        win_clr = 1'b0;
        lv_clr  = 1'b0;
        drv_up  = 1'b0;
        eq_up   = 1'b0;
        exhaust = 1'b0;
        win_lim = (st == ST_PH2) ? TW'(P2_WIN) : TW'(P1_WIN);
        case (st)
            ST_IDLE, ST_FAIL: begin
                if (plug_evt) begin
                    st_n    = ST_PH1;
                    rate_n  = 1'b0;
                    lanes_n = clamp_lanes(lane_req);
                    p1_n    = '0;
                    p2_n    = '0;
                    win_clr = 1'b1;
                    lv_clr  = 1'b1;
                end
            end
            ST_PH1: begin
                if (all_freq) begin
                    st_n    = ST_PH2;
                    p2_n    = '0;
                    win_clr = 1'b1;
                end else if (win_last) begin
                    if (p1_try == P1W'(P1_TRIES - 1)) begin
                        exhaust = 1'b1;
                    end else begin
                        p1_n    = p1_try + P1W'(1);
                        drv_up  = 1'b1;
                        win_clr = 1'b1;
                    end
                end
            end
            ST_PH2: begin
                if (win_last) begin
                    if (all_sym && (err_tot <= thresh)) begin
                        st_n = ST_READY;
                    end else if (p2_try == P2W'(P2_TRIES - 1)) begin
                        exhaust = 1'b1;
                    end else begin
                        p2_n    = p2_try + P2W'(1);
                        eq_up   = 1'b1;
                        win_clr = 1'b1;
                    end
                end
            end
            ST_READY: begin
                if (!(all_freq && all_sym)) begin
                    st_n    = ST_PH1;
                    p1_n    = '0;
                    attn_n  = 1'b1;
                    win_clr = 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase
        if (exhaust) begin
            if (!rate_low) begin
                rate_n  = 1'b1;
                st_n    = ST_PH1;
                p1_n    = '0;
                p2_n    = '0;
                win_clr = 1'b1;
                lv_clr  = 1'b1;
            end else begin
                st_n   = ST_FAIL;
                attn_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            rate_low  <= 1'b0;
            lanes_act <= '0;
            p1_try    <= '0;
            p2_try    <= '0;
            attn      <= 1'b0;
        end else begin
            st        <= st_n;
            rate_low  <= rate_n;
            lanes_act <= lanes_n;
            p1_try    <= p1_n;
            p2_try    <= p2_n;
            attn      <= attn_n;
        end
    end

    assign train_st   = st;
    assign link_ready = (st == ST_READY);
    assign drive_lvl  = lv.drive;
    assign pre_lvl    = lv.pre;
    assign eq_en      = lv.eq_en;
    assign eq_lvl     = lv.eq;

    AST_PH2_AFTER_PH1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PH2 && $past(st) != ST_PH2) |-> $past(st) == ST_PH1); // R3
    AST_READY_FROM_PH2: assert property (@(posedge clk) disable iff (rst)
        $rose(link_ready) |-> $past(st) == ST_PH2); // R5
    AST_RATE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (rate_low && !(plug_evt && (st == ST_IDLE || st == ST_FAIL))) |=> rate_low); // R8
    AST_FAIL_LOW_RATE: assert property (@(posedge clk) disable iff (rst)
        st == ST_FAIL |-> rate_low); // R9
    AST_ATTN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        attn |=> !attn); // R10
    AST_LANES_HELD: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && st != ST_FAIL) |=> $stable(lanes_act)); // R2

endmodule

// File: tb/sim_link_train_ctrl.sv
module sim_link_train_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       plug_evt;
    logic [2:0] lane_req;
    logic [7:0] thresh;
    logic [3:0] freq_lock, sym_lock, err_evt;
    logic [2:0] train_st;
    logic [1:0] drive_lvl, pre_lvl, eq_lvl;
    logic       eq_en, rate_low, link_ready, attn;
    logic [2:0] lanes_act;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    link_train_ctrl u0 (
        .clk(clk), .rst(rst), .plug_evt(plug_evt), .lane_req(lane_req),
        .thresh(thresh), .freq_lock(freq_lock), .sym_lock(sym_lock),
        .err_evt(err_evt), .train_st(train_st), .drive_lvl(drive_lvl),
        .pre_lvl(pre_lvl), .eq_en(eq_en), .eq_lvl(eq_lvl),
        .rate_low(rate_low), .lanes_act(lanes_act),
        .link_ready(link_ready), .attn(attn)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; plug_evt = 1'b0; lane_req = '0; thresh = '0;
        freq_lock = '0; sym_lock = '0; err_evt = '0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic plug(input int req);
        plug_evt = 1'b1; lane_req = 3'(req);
        tick();
        plug_evt = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 state", train_st, 0);
        chk("R1 ready", link_ready, 0);
        chk("R1 attn", attn, 0);
        chk("R1 rate", rate_low, 0);
        chk("R1 lanes", lanes_act, 0);
        chk("R1 levels", {drive_lvl, pre_lvl, eq_en, eq_lvl}, 0);

        // R2 lane clamp sweep
        for (int r = 0; r < 8; r++) begin
            do_reset();
            plug(r);
            chk("R2 state", train_st, 1);
            chk("R2 lanes", lanes_act, (r == 0) ? 1 : (r > 4 ? 4 : r));
        end

        // R3 only active lanes need frequency lock
        do_reset();
        freq_lock = 4'b1101;
        plug(2);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R3 missing active lock", train_st, 1);
        end
        freq_lock = 4'b0011;
        tick();
        chk("R3 enter phase two", train_st, 2);

        // R4 R8 R9 drive ramp, fallback and failure
        do_reset();
        plug(4);
        for (int n = 1; n <= 80; n++) begin
            tick();
            if (n < 40) begin
                chk("R4 state", train_st, 1);
                chk("R4 drive", drive_lvl, (n / 8 > 3) ? 3 : n / 8);
                chk("R4 rate", rate_low, 0);
            end else if (n < 80) begin
                chk("R8 state", train_st, 1);
                chk("R8 rate", rate_low, 1);
                chk("R8 drive", drive_lvl, ((n - 40) / 8 > 3) ? 3 : (n - 40) / 8);
            end else begin
                chk("R9 state", train_st, 4);
                chk("R9 attn", attn, 1);
                chk("R9 ready", link_ready, 0);
            end
        end
        tick();
        chk("R9 attn single", attn, 0);
        chk("R9 stays failed", train_st, 4);
        plug(1);
        chk("R2 replug state", train_st, 1);
        chk("R2 replug rate", rate_low, 0);
        chk("R2 replug drive", drive_lvl, 0);

        // R5 R6 error count sweep around threshold, noise on inactive lanes
        for (int e = 0; e <= 6; e++) begin
            do_reset();
            freq_lock = 4'b0011; sym_lock = 4'b0011; thresh = 8'd3;
            plug(2);
            tick();
            chk("R5 phase two", train_st, 2);
            for (int i = 0; i < 16; i++) begin
                err_evt = {2'b11, 1'b0, (i < e)};
                tick();
            end
            err_evt = '0;
            chk("R5 window result", train_st, (e <= 3) ? 3 : 2);
            chk("R5 ready", link_ready, (e <= 3) ? 1 : 0);
            chk("R6 pre step", pre_lvl, (e <= 3) ? 0 : 1);
            chk("R6 eq enable", eq_en, (e <= 3) ? 0 : 1);
        end

        // R5 two errors in one cycle against thresholds 0..3
        for (int t = 0; t < 4; t++) begin
            do_reset();
            freq_lock = 4'b1111; sym_lock = 4'b1111; thresh = 8'(t);
            plug(2);
            tick();
            for (int i = 0; i < 16; i++) begin
                err_evt = (i == 5) ? 4'b0011 : 4'b0000;
                tick();
            end
            err_evt = '0;
            chk("R5 double error", train_st, (t >= 2) ? 3 : 2);
        end

        // R5 missing symbol lock on an active lane fails the window
        do_reset();
        freq_lock = 4'b0011; sym_lock = 4'b0001; thresh = 8'd9;
        plug(2);
        tick();
        repeat (16) tick();
        chk("R5 no sym lock", train_st, 2);
        chk("R6 eq level", eq_lvl, 1);

        // R6 R7 R8 repeated phase-two failure at high rate
        do_reset();
        freq_lock = 4'b1111; sym_lock = 4'b1111; thresh = 8'd0;
        plug(4);
        tick();
        for (int w = 0; w < 3; w++) begin
            for (int i = 0; i < 16; i++) begin
                err_evt = 4'b0001;
                tick();
            end
            if (w < 2) begin
                chk("R6 state", train_st, 2);
                chk("R6 pre", pre_lvl, w + 1);
                chk("R6 eq", eq_lvl, w + 1);
            end else begin
                chk("R7 fallback state", train_st, 1);
                chk("R8 rate low", rate_low, 1);
                chk("R8 pre cleared", pre_lvl, 0);
                chk("R8 eq cleared", eq_en, 0);
            end
        end
        err_evt = '0;

        // R10 lock loss in ready, R2 plug ignored in ready
        do_reset();
        freq_lock = 4'b1111; sym_lock = 4'b1111; thresh = 8'd0;
        plug(3);
        tick();
        repeat (16) tick();
        chk("R10 ready", train_st, 3);
        plug(1);
        chk("R2 plug ignored state", train_st, 3);
        chk("R2 plug ignored lanes", lanes_act, 3);
        freq_lock = 4'b0111;
        tick();
        chk("R10 inactive lock loss", train_st, 3);
        chk("R10 no attn", attn, 0);
        sym_lock = 4'b1011;
        tick();
        chk("R10 back to phase one", train_st, 1);
        chk("R10 attn", attn, 1);
        chk("R10 not ready", link_ready, 0);
        chk("R10 rate kept", rate_low, 0);
        tick();
        chk("R10 attn single", attn, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule